// File: doc/BRIEF.md
# Multiplexed Bus Cycle Generator

This block is the external-memory side of a small 8-bit controller. It runs a fixed machine cycle of five clocks and, in each one, performs at most one transfer on a shared address/data bus of 8 lines, plus a 4-line high-address nibble port. The three transfer kinds are instruction fetch from external program store, data read and data write. Each transfer has its own active-low strobe. An address-latch pulse is produced in every machine cycle, whether or not a transfer takes place.

The requester presents a cycle kind, an address and write data. These are sampled at the clock edge that closes a machine cycle, and `slot_o` marks the clock in which that edge comes. A fetched byte or a read byte comes back on its own output, together with a one-clock valid pulse. The lines of the bus and of the nibble port are driven only when an output-enable says so. Outside a transfer they float.

Top module: `bus_cycle_gen`

## Requirements
- R1: `ale_o` is high for exactly one clock in every five-clock machine cycle, the second clock (phase 1), in idle cycles as well as in transfer cycles.
- R2: `req_kind_i`, `req_addr_i` and `req_wdata_i` are sampled only at the rising edge that ends a clock where `slot_o` is high (phase 4). Kind encoding: 0 idle, 1 fetch, 2 read, 3 write. Values applied at other times have no effect.
- R3: In a fetch cycle, `bus_o` carries address bits 7:0 with `bus_oe_o` high in phases 0 to 2. `nib_o` carries address bits 11:8 with `nib_oe_o` high in all five phases.
- R4: `psen_no` is low only in phase 3 of a fetch cycle, and the bus is released (`bus_oe_o` low) in phases 3 and 4.
- R5: The instruction byte is taken from `bus_i` at the edge that ends phase 3. It appears on `instr_o` with `instr_vld_o` high during phase 4 only, and `instr_o` holds its value until the next fetch.
- R6: In a read cycle, address bits 7:0 are on the bus in phases 0 to 2, `rd_no` is low in phase 3, and the bus is released in phases 3 and 4. The nibble port is not driven. The byte on `bus_i` at the end of phase 3 appears on `rdata_o` with `rdata_vld_o` high during phase 4 only.
- R7: In a write cycle, the address is on the bus in phases 0 to 2 and the write data in phases 3 and 4, with `bus_oe_o` high in all five phases. `wr_no` is low in phase 3 only. The nibble port is not driven.
- R8: At most one of `psen_no`, `rd_no` and `wr_no` is low at any time, and none is low while `ale_o` is high.
- R9: In an idle cycle all strobes stay high, `bus_oe_o` and `nib_oe_o` stay low, and both valid outputs stay low.
- R10: While `rst_ni` is low, `bus_oe_o`, `nib_oe_o`, `ale_o` and both valids are low and all strobes are high. The first machine cycle after reset is idle, whatever the request inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one machine-cycle phase per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_kind_i | input | 2 | Cycle kind for the next machine cycle |
| req_addr_i | input | 12 | Program address (fetch) or data address in bits 7:0 |
| req_wdata_i | input | 8 | Data for a write cycle |
| slot_o | output | 1 | High in the clock whose closing edge samples the request |
| bus_i | input | 8 | Value on the multiplexed bus lines |
| bus_o | output | 8 | Value to drive on the multiplexed bus |
| bus_oe_o | output | 1 | Bus output enable |
| nib_o | output | 4 | High-address nibble |
| nib_oe_o | output | 1 | Nibble port output enable |
| ale_o | output | 1 | Address latch enable |
| psen_no | output | 1 | Program store strobe, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| instr_o | output | 8 | Last fetched instruction byte |
| instr_vld_o | output | 1 | One-clock pulse when a fetch completes |
| rdata_o | output | 8 | Last read data byte |
| rdata_vld_o | output | 1 | One-clock pulse when a read completes |

## Verification
Completing one transfer and accepting the next request fall in the same clock. The valid pulse and captured byte of a fetch or read appear in phase 4, which is exactly the clock in which `slot_o` is high and the next kind and address are sampled. Back-to-back vectors provoke this overlap: a read followed at once by a write, a fetch followed at once by a read, and a transfer followed by an idle cycle. The bench judges it by checking the returned byte and its pulse in phase 4 of one cycle. In the next cycle it checks that phase 0 already drives the new address, or floats the bus for an idle request.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [2:0] {
    PH_ADDR   = 3'd0,
    PH_ALE    = 3'd1,
    PH_LATCH  = 3'd2,
    PH_STROBE = 3'd3,
    PH_REL    = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_FETCH = 2'd1,
    CYC_READ  = 2'd2,
    CYC_WRITE = 2'd3
  } cyc_e;
endpackage

// File: rtl/bcg_phase_seq.sv
module bcg_phase_seq
  import bcg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e phase_o,
  output logic   slot_o
);
  phase_e phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_q <= PH_ADDR;
    else if (phase_q == PH_REL) phase_q <= PH_ADDR;
    else                        phase_q <= phase_e'(phase_q + 3'd1);
  end

  assign phase_o = phase_q;
  assign slot_o  = (phase_q == PH_REL);

  AST_SLOT_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o |=> (phase_o == PH_ADDR)); // R2
endmodule

// File: rtl/bcg_cycle_reg.sv
module bcg_cycle_reg
  import bcg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cyc_e              kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o  <= CYC_IDLE;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (take_i) begin
      kind_o  <= cyc_e'(kind_i);
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/bcg_pin_ctl.sv
module bcg_pin_ctl
  import bcg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  cyc_e              kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic [HI_W-1:0]   nib_o,
  output logic              nib_oe_o,
  output logic              ale_o,
  output logic              psen_no,
  output logic              rd_no,
  output logic              wr_no
);
  logic addr_ph, strb_ph, data_ph, is_fetch, is_read, is_write;

  always_comb begin
    addr_ph  = (phase_i == PH_ADDR) || (phase_i == PH_ALE) || (phase_i == PH_LATCH);
    strb_ph  = (phase_i == PH_STROBE);
    data_ph  = strb_ph || (phase_i == PH_REL);
    is_fetch = (kind_i == CYC_FETCH);
    is_read  = (kind_i == CYC_READ);
    is_write = (kind_i == CYC_WRITE);

    ale_o    = (phase_i == PH_ALE);
    bus_oe_o = ((kind_i != CYC_IDLE) && addr_ph) || (is_write && data_ph);
    bus_o    = '0;
    if (addr_ph && kind_i != CYC_IDLE) bus_o = addr_i[DATA_W-1:0];
    else if (is_write && data_ph)      bus_o = wdata_i;
    nib_oe_o = is_fetch;
    nib_o    = is_fetch ? addr_i[ADDR_W-1:DATA_W] : '0;
    psen_no  = !(is_fetch && strb_ph);
    rd_no    = !(is_read  && strb_ph);
    wr_no    = !(is_write && strb_ph);
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~psen_no, ~rd_no, ~wr_no}) <= 1); // R8
  AST_NO_STROBE_AT_ALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (psen_no && rd_no && wr_no)); // R8
  AST_FLOAT_ON_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psen_no || !rd_no) |-> !bus_oe_o); // R4
  AST_WR_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> bus_oe_o); // R7
  AST_PSEN_NIB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_no |-> nib_oe_o); // R3
endmodule

// File: rtl/bcg_capture.sv
module bcg_capture
  import bcg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  cyc_e              kind_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] instr_o,
  output logic              instr_vld_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_vld_o
);
  logic last_strb;
  assign last_strb = (phase_i == PH_STROBE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_o     <= '0;
      rdata_o     <= '0;
      instr_vld_o <= 1'b0;
      rdata_vld_o <= 1'b0;
    end else begin
      instr_vld_o <= last_strb && (kind_i == CYC_FETCH);
      rdata_vld_o <= last_strb && (kind_i == CYC_READ);
      if (last_strb && kind_i == CYC_FETCH) instr_o <= bus_i;
      if (last_strb && kind_i == CYC_READ)  rdata_o <= bus_i;
    end
  end

  AST_IVLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_vld_o |=> !instr_vld_o); // R5
  AST_RVLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_vld_o |=> !rdata_vld_o); // R6
endmodule

// File: rtl/bus_cycle_gen.sv
module bus_cycle_gen
  import bcg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              slot_o,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic [HI_W-1:0]   nib_o,
  output logic              nib_oe_o,
  output logic              ale_o,
  output logic              psen_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic [DATA_W-1:0] instr_o,
  output logic              instr_vld_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_vld_o
);
  phase_e            phase;
  cyc_e              cur_kind;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;

  bcg_phase_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase),
    .slot_o  (slot_o)
  );

  bcg_cycle_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_creg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (slot_o),
    .kind_i  (req_kind_i),
    .addr_i  (req_addr_i),
    .wdata_i (req_wdata_i),
    .kind_o  (cur_kind),
    .addr_o  (cur_addr),
    .wdata_o (cur_wdata)
  );

  bcg_pin_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phase_i  (phase),
    .kind_i   (cur_kind),
    .addr_i   (cur_addr),
    .wdata_i  (cur_wdata),
    .bus_o    (bus_o),
    .bus_oe_o (bus_oe_o),
    .nib_o    (nib_o),
    .nib_oe_o (nib_oe_o),
    .ale_o    (ale_o),
    .psen_no  (psen_no),
    .rd_no    (rd_no),
    .wr_no    (wr_no)
  );

  bcg_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_i     (phase),
    .kind_i      (cur_kind),
    .bus_i       (bus_i),
    .instr_o     (instr_o),
    .instr_vld_o (instr_vld_o),
    .rdata_o     (rdata_o),
    .rdata_vld_o (rdata_vld_o)
  );

  AST_ALE_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o); // R1
  AST_ALE_BEFORE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o |-> !ale_o); // R1
  AST_IVLD_AFTER_PSEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_vld_o |-> $past(!psen_no)); // R5
  AST_RVLD_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_vld_o |-> $past(!rd_no)); // R6
endmodule

// File: tb/bus_cycle_gen_test.sv
module bus_cycle_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  kind = 2'd0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  bus_in = '0;
  logic        slot, bus_oe, nib_oe, ale, psen_n, rd_n, wr_n, ivld, rvld;
  logic [7:0]  bus_out, instr, rdata;
  logic [3:0]  nib;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bus_cycle_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .req_kind_i(kind), .req_addr_i(addr),
    .req_wdata_i(wdata), .slot_o(slot), .bus_i(bus_in), .bus_o(bus_out),
    .bus_oe_o(bus_oe), .nib_o(nib), .nib_oe_o(nib_oe), .ale_o(ale),
    .psen_no(psen_n), .rd_no(rd_n), .wr_no(wr_n), .instr_o(instr),
    .instr_vld_o(ivld), .rdata_o(rdata), .rdata_vld_o(rvld)
  );

  // {kind, addr, wdata, bus response}
  localparam logic [29:0] VECS [0:9] = '{
    {2'd1, 12'hA5C, 8'h00, 8'h3C},
    {2'd2, 12'h0F1, 8'h00, 8'h96},
    {2'd3, 12'h722, 8'hE7, 8'h55},
    {2'd0, 12'hFFF, 8'hFF, 8'hAA},
    {2'd1, 12'h001, 8'h11, 8'hC3},
    {2'd1, 12'hFFE, 8'h22, 8'h5A},
    {2'd2, 12'h980, 8'h33, 8'h01},
    {2'd3, 12'h3FF, 8'h00, 8'hFE},
    {2'd2, 12'h444, 8'h00, 8'h80},
    {2'd0, 12'h000, 8'h00, 8'h00}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // {ale, psen_n, rd_n, wr_n, bus_oe, nib_oe, bus[8], nib[4]}
  function automatic logic [17:0] model(input logic [1:0] k, input logic [11:0] a,
                                        input logic [7:0] w, input int ph);
    logic fe, re, we, boe;
    logic [7:0] b;
    fe = (k == 2'd1); re = (k == 2'd2); we = (k == 2'd3);
    boe = (k != 2'd0 && ph < 3) || (we && ph >= 3);
    b = boe ? ((ph < 3) ? a[7:0] : w) : 8'h00;
    return {ph == 1, !(fe && ph == 3), !(re && ph == 3), !(we && ph == 3),
            boe, fe, b, fe ? a[11:8] : 4'h0};
  endfunction

  function automatic logic [17:0] seen(input logic [17:0] e);
    return {ale, psen_n, rd_n, wr_n, bus_oe, nib_oe,
            e[13] ? bus_out : 8'h00, e[12] ? nib : 4'h0};
  endfunction

  task automatic run_cycle(input logic [29:0] v);
    logic [1:0] k;
    logic [17:0] e;
    string tag;
    k = v[29:28];
    while (!slot) @(negedge clk);
    kind = k; addr = v[27:16]; wdata = v[15:8]; bus_in = v[7:0];
    for (int ph = 0; ph < 5; ph++) begin
      @(negedge clk);
      e = model(k, v[27:16], v[15:8], ph);
      case (k)
        2'd0: tag = "R9";
        2'd1: tag = (ph == 1) ? "R1" : (ph < 3) ? "R3" : "R4";
        2'd2: tag = (ph == 1) ? "R1" : "R6";
        default: tag = (ph == 1) ? "R1" : "R7";
      endcase
      check(seen(e) == e, tag, 32'(seen(e)), 32'(e));
      check(!(!psen_n + !rd_n + !wr_n > 1) && !(ale && !(psen_n && rd_n && wr_n)),
            "R8", {28'd0, ale, psen_n, rd_n, wr_n}, 32'h7);
      if (ph == 4) begin
        check(slot, "R2", 32'(slot), 32'd1);
        check(ivld == (k == 2'd1) && rvld == (k == 2'd2), (k == 2'd0) ? "R9" : "R5",
              {30'd0, ivld, rvld}, {30'd0, k == 2'd1, k == 2'd2});
        if (k == 2'd1) check(instr == v[7:0], "R5", 32'(instr), 32'(v[7:0]));
        if (k == 2'd2) check(rdata == v[7:0], "R6", 32'(rdata), 32'(v[7:0]));
      end else begin
        check(!ivld && !rvld && !slot, "R2", {29'd0, slot, ivld, rvld}, 32'd0);
      end
    end
  endtask

  initial begin
    logic [7:0] keep;
    kind = 2'd3; addr = 12'h155; wdata = 8'h99;
    #35;
    // reset state
    check({bus_oe, nib_oe, ale, psen_n, rd_n, wr_n, ivld, rvld} == 8'b00011100, "R10",
          {24'd0, bus_oe, nib_oe, ale, psen_n, rd_n, wr_n, ivld, rvld}, 32'h1C);
    @(negedge clk); rst_n = 1'b1;
    // first cycle after reset idle despite write request held
    for (int ph = 0; ph < 5; ph++) begin
      check(!bus_oe && wr_n && (ale == (ph == 1)), "R10",
            {29'd0, bus_oe, wr_n, ale}, {29'd0, 1'b0, 1'b1, ph == 1});
      if (ph < 4) @(negedge clk);
    end
    for (int i = 0; i < 10; i++) run_cycle(VECS[i]);
    // idle cycle: ALE still pulses
    run_cycle({2'd0, 12'h000, 8'h00, 8'h00});
    // request presented off-slot then withdrawn is ignored
    @(negedge clk);
    kind = 2'd2; addr = 12'h0AA;
    @(negedge clk); @(negedge clk);
    kind = 2'd0;
    while (!slot) @(negedge clk);
    @(negedge clk);
    check(!bus_oe && rd_n, "R2", {30'd0, bus_oe, rd_n}, 32'd1);
    for (int ph = 1; ph < 5; ph++) begin
      @(negedge clk);
      check(rd_n && !bus_oe && (ale == (ph == 1)) && !rvld, "R2",
            {28'd0, rd_n, bus_oe, ale, rvld}, {28'd0, 1'b1, 1'b0, ph == 1, 1'b0});
    end
    // instr holds across non-fetch cycles
    keep = instr;
    run_cycle({2'd2, 12'h010, 8'h00, 8'h77});
    check(instr == keep, "R5", 32'(instr), 32'(keep));
    // async reset during a write strobe floats the bus at once
    while (!slot) @(negedge clk);
    kind = 2'd3; addr = 12'h0C0; wdata = 8'h5E;
    repeat (4) @(negedge clk);
    check(!wr_n && bus_oe, "R7", {30'd0, wr_n, bus_oe}, 32'd1);
    rst_n = 1'b0; #1;
    check(!bus_oe && wr_n && !ale && !nib_oe, "R10",
          {28'd0, bus_oe, wr_n, ale, nib_oe}, 32'h4);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!bus_oe && wr_n, "R10", {30'd0, bus_oe, wr_n}, 32'd1);
    kind = 2'd0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule